// File: doc/BRIEF.md
# PS/2 Mouse Movement Packet Receiver

This block is the host-side receive path for a PS/2 pointing device. It watches the already-synchronized clock and data lines of the mouse. On every falling edge of the mouse clock it captures one data bit. It frames each 11-bit word (start, eight data bits least significant first, odd parity, stop) and gathers three good words into one movement packet.

The first word of a packet is a status byte and the other two are movement magnitudes. The block joins each magnitude with its sign bit from the status byte to form a 9-bit two's-complement displacement. It then presents both displacements, the two button states and the two overflow flags, all held until the next packet, and strobes a packet-valid output for one cycle.

A word that fails its parity or stop check discards the whole packet and pulses an error output. A status word without its marker bit is dropped as misaligned. A long idle gap in the middle of a packet resets the word collection, so the receiver realigns with the mouse. The block sits between a two-flop synchronizer and whatever logic moves a cursor.

Top module: `ps2m_decoder`

## Requirements
- R1: After reset, all outputs are 0: `dx_o`, `dy_o`, both button outputs, both overflow outputs, `pkt_valid_o` and `frame_err_o`.
- R2: Three valid words in a row, the first with status bit 3 set, produce exactly one `pkt_valid_o` pulse. `btn_left_o` equals status bit 0 and `btn_right_o` equals status bit 1.
- R3: `dx_o` is {status bit 4, second byte} and `dy_o` is {status bit 5, third byte}, each read as a 9-bit two's-complement number. These outputs change only on a cycle with `pkt_valid_o` high.
- R4: `ovf_x_o` equals status bit 6 and `ovf_y_o` equals status bit 7, updated only with a packet.
- R5: A word whose nine data-plus-parity bits hold an even number of ones pulses `frame_err_o`. No packet is produced and the held outputs keep their values.
- R6: A word whose stop bit reads 0 pulses `frame_err_o` in the same way.
- R7: A word taken as status with bit 3 clear is dropped without an error. The next word is again taken as a status word.
- R8: If the mouse clock stays high for `IDLE_LIMIT` system cycles in the middle of a packet, the partial packet is abandoned. The next word starts a new packet.
- R9: After a framing error, all further words are ignored until an idle gap of `IDLE_LIMIT` cycles. After that gap, a complete packet decodes normally.
- R10: Bits are captured on the falling edge of the mouse clock. A low data level on a falling edge with no word in progress begins a word, and a high level there is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ps2_clk_i | input | 1 | Synchronized mouse clock line |
| ps2_dat_i | input | 1 | Synchronized mouse data line |
| dx_o | output | 9 | Signed horizontal displacement, positive to the right |
| dy_o | output | 9 | Signed vertical displacement, positive upward |
| btn_left_o | output | 1 | Left button pressed |
| btn_right_o | output | 1 | Right button pressed |
| ovf_x_o | output | 1 | Horizontal movement overflow |
| ovf_y_o | output | 1 | Vertical movement overflow |
| pkt_valid_o | output | 1 | One-cycle strobe when a new packet is presented |
| frame_err_o | output | 1 | One-cycle strobe on a parity or stop-bit error |

## Verification
A word counter that has slipped shows up at the ports on the next packet. The status byte lands in a displacement field, and the marker check either swallows the packet or shifts every field by one byte. A parity or stop check that is wrong flips the error strobe within one system cycle of the last falling edge of the bad word. A broken discard or idle-gap recovery turns the very next packet into a missing strobe or into shuffled fields. Every scenario is therefore judged on the strobe counts and on the held field values right after the packet that should follow.

// File: rtl/ps2m_pkg.sv
// Package: shared constants and types for the PS/2 mouse receiver.
// Assumes the standard 3-byte movement packet with the status byte first.
package ps2m_pkg;
    localparam int BYTE_W   = 8;
    localparam int DISP_W   = BYTE_W + 1;
    localparam int WORD_BITS = 11;
    localparam int ST_LEFT  = 0;
    localparam int ST_RIGHT = 1;
    localparam int ST_MARK  = 3;
    localparam int ST_XSIGN = 4;
    localparam int ST_YSIGN = 5;
    localparam int ST_XOVF  = 6;
    localparam int ST_YOVF  = 7;

    typedef enum logic [1:0] {
        COL_STATUS  = 2'd0,
        COL_XMAG    = 2'd1,
        COL_YMAG    = 2'd2,
        COL_DISCARD = 2'd3
    } collect_e;

    typedef struct packed {
        logic                left;
        logic                right;
        logic                ovf_x;
        logic                ovf_y;
        logic [DISP_W-1:0]   dx;
        logic [DISP_W-1:0]   dy;
    } motion_t;
endpackage

// File: rtl/ps2m_word_rx.sv
// Module: receives one framed 11-bit PS/2 word at a time.
// Assumes ps2_clk_i/ps2_dat_i are already synchronous to clk. Bits are taken
// on falling edges of the mouse clock. A long idle gap raises gap_o for one
// cycle and abandons any partial word.
module ps2m_word_rx
    import ps2m_pkg::*;
#(
    parameter int IDLE_LIMIT = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ps2_clk_i,
    input  logic              ps2_dat_i,
    output logic              word_ok_o,
    output logic              word_bad_o,
    output logic [BYTE_W-1:0] word_data_o,
    output logic              gap_o
);
    localparam int CNT_W  = $clog2(WORD_BITS + 1);
    localparam int TMR_W  = $clog2(IDLE_LIMIT + 1);
    localparam int SH_W   = WORD_BITS - 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);
    localparam logic [TMR_W-1:0] TMR_MAX  = TMR_W'(IDLE_LIMIT);

    logic              clk_q;
    logic              fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [SH_W-1:0]   shreg;
    logic [SH_W-1:0]   sh_next;
    logic [TMR_W-1:0]  idle_tmr;
    logic              gap_hit;

    assign fall    = clk_q & ~ps2_clk_i;
    assign sh_next = {ps2_dat_i, shreg[SH_W-1:1]};
    assign gap_hit = ~fall && (idle_tmr == TMR_MAX - 1'b1);

    // Remember the previous mouse clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_q <= 1'b1;
        else        clk_q <= ps2_clk_i;
    end

    // Idle timer: cleared by each falling edge, saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_tmr <= '0;
            gap_o    <= 1'b0;
        end else begin
            gap_o <= gap_hit;
            if (fall)                    idle_tmr <= '0;
            else if (idle_tmr != TMR_MAX) idle_tmr <= idle_tmr + 1'b1;
        end
    end

    // Bit counter and shift register; emits a checked word after the stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            shreg       <= '0;
            word_ok_o   <= 1'b0;
            word_bad_o  <= 1'b0;
            word_data_o <= '0;
        end else begin
            word_ok_o  <= 1'b0;
            word_bad_o <= 1'b0;
            if (gap_hit) begin
                bit_cnt <= '0;
            end else if (fall) begin
                if (bit_cnt == '0) begin
                    if (!ps2_dat_i) bit_cnt <= CNT_W'(1);
                end else begin
                    shreg <= sh_next;
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt     <= '0;
                        word_data_o <= sh_next[BYTE_W-1:0];
                        if ((^sh_next[BYTE_W:0]) && sh_next[SH_W-1])
                            word_ok_o  <= 1'b1;
                        else
                            word_bad_o <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ps2m_packet_asm.sv
// Module: gathers status, X and Y bytes into one movement packet.
// Assumes word strobes last one cycle. An error blocks collection until the
// next idle gap. A status byte without its marker bit is dropped.
module ps2m_packet_asm
    import ps2m_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_ok_i,
    input  logic              word_bad_i,
    input  logic [BYTE_W-1:0] word_data_i,
    input  logic              gap_i,
    output motion_t           motion_o,
    output logic              pkt_valid_o,
    output logic              frame_err_o
);
    collect_e          state;
    logic [BYTE_W-1:0] status_q;
    logic [BYTE_W-1:0] xmag_q;

    // Collection state machine with capture of the first two bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= COL_STATUS;
            status_q    <= '0;
            xmag_q      <= '0;
            pkt_valid_o <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            pkt_valid_o <= 1'b0;
            frame_err_o <= 1'b0;
            if (gap_i) begin
                state <= COL_STATUS;
            end else if (word_bad_i && state != COL_DISCARD) begin
                state       <= COL_DISCARD;
                frame_err_o <= 1'b1;
            end else if (word_ok_i) begin
                unique case (state)
                    COL_STATUS: begin
                        if (word_data_i[ST_MARK]) begin
                            status_q <= word_data_i;
                            state    <= COL_XMAG;
                        end
                    end
                    COL_XMAG: begin
                        xmag_q <= word_data_i;
                        state  <= COL_YMAG;
                    end
                    COL_YMAG: begin
                        pkt_valid_o <= 1'b1;
                        state       <= COL_STATUS;
                    end
                    default: state <= COL_DISCARD;
                endcase
            end
        end
    end

    // Output register: loads the decoded fields when the third byte lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            motion_o <= '0;
        end else if (word_ok_i && !gap_i && state == COL_YMAG) begin
            motion_o.left  <= status_q[ST_LEFT];
            motion_o.right <= status_q[ST_RIGHT];
            motion_o.ovf_x <= status_q[ST_XOVF];
            motion_o.ovf_y <= status_q[ST_YOVF];
            motion_o.dx    <= {status_q[ST_XSIGN], xmag_q};
            motion_o.dy    <= {status_q[ST_YSIGN], word_data_i};
        end
    end
endmodule

// File: rtl/ps2m_decoder.sv
// Module: top of the PS/2 mouse receiver; word framing then packet assembly.
// Assumes synchronized inputs and a system clock far faster than 30 kHz.
module ps2m_decoder
    import ps2m_pkg::*;
#(
    parameter int IDLE_LIMIT = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ps2_clk_i,
    input  logic              ps2_dat_i,
    output logic [DISP_W-1:0] dx_o,
    output logic [DISP_W-1:0] dy_o,
    output logic              btn_left_o,
    output logic              btn_right_o,
    output logic              ovf_x_o,
    output logic              ovf_y_o,
    output logic              pkt_valid_o,
    output logic              frame_err_o
);
    logic              w_ok;
    logic              w_bad;
    logic [BYTE_W-1:0] w_data;
    logic              w_gap;
    motion_t           motion;

    ps2m_word_rx #(.IDLE_LIMIT(IDLE_LIMIT)) u_word (
        .clk         (clk),
        .rst_n       (rst_n),
        .ps2_clk_i   (ps2_clk_i),
        .ps2_dat_i   (ps2_dat_i),
        .word_ok_o   (w_ok),
        .word_bad_o  (w_bad),
        .word_data_o (w_data),
        .gap_o       (w_gap)
    );

    ps2m_packet_asm u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_ok_i   (w_ok),
        .word_bad_i  (w_bad),
        .word_data_i (w_data),
        .gap_i       (w_gap),
        .motion_o    (motion),
        .pkt_valid_o (pkt_valid_o),
        .frame_err_o (frame_err_o)
    );

    assign dx_o        = motion.dx;
    assign dy_o        = motion.dy;
    assign btn_left_o  = motion.left;
    assign btn_right_o = motion.right;
    assign ovf_x_o     = motion.ovf_x;
    assign ovf_y_o     = motion.ovf_y;
endmodule

// File: rtl/ps2m_decoder_chk.sv
// Checker: temporal properties of the receiver outputs, bound to the top.
module ps2m_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [8:0] dx_o,
    input logic [8:0] dy_o,
    input logic       btn_left_o,
    input logic       btn_right_o,
    input logic       ovf_x_o,
    input logic       ovf_y_o,
    input logic       pkt_valid_o,
    input logic       frame_err_o
);
    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_o |=> !pkt_valid_o);
    assert_disp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(dx_o) && $stable(dy_o) && $stable(btn_left_o) && $stable(btn_right_o))
        |-> pkt_valid_o);
    assert_ovf_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(ovf_x_o) && $stable(ovf_y_o)) |-> pkt_valid_o);
    assert_err_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_valid_o && frame_err_o));
    assert_err_no_pkt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !pkt_valid_o);
endmodule

bind ps2m_decoder ps2m_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dx_o        (dx_o),
    .dy_o        (dy_o),
    .btn_left_o  (btn_left_o),
    .btn_right_o (btn_right_o),
    .ovf_x_o     (ovf_x_o),
    .ovf_y_o     (ovf_y_o),
    .pkt_valid_o (pkt_valid_o),
    .frame_err_o (frame_err_o)
);

// File: tb/ps2m_decoder_bench.sv
module ps2m_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IDLE       = 100;
    localparam int HALF       = 10;
    localparam int NVEC       = 6;
    // {status, x magnitude, y magnitude}
    localparam logic [23:0] VEC [NVEC] = '{
        24'h08_00_00, 24'h09_05_03, 24'h3A_FB_FD,
        24'hC8_FF_7F, 24'h1B_00_80, 24'h28_7F_01
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pclk = 1'b1;
    logic       pdat = 1'b1;
    logic [8:0] dx, dy;
    logic       bl, br, ox, oy, pv, fe;
    int         n_chk = 0, n_bad = 0;
    int         n_valid = 0, n_err = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ps2m_decoder #(.IDLE_LIMIT(IDLE)) u_ps2m_decoder (
        .clk(clk), .rst_n(rst_n), .ps2_clk_i(pclk), .ps2_dat_i(pdat),
        .dx_o(dx), .dy_o(dy), .btn_left_o(bl), .btn_right_o(br),
        .ovf_x_o(ox), .ovf_y_o(oy), .pkt_valid_o(pv), .frame_err_o(fe)
    );

    // Strobe counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && pv) n_valid++;
        if (rst_n && fe) n_err++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        pdat = b;
        repeat (HALF) @(negedge clk);
        pclk = 1'b0;
        repeat (HALF) @(negedge clk);
        pclk = 1'b1;
    endtask

    task automatic send_word(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        bit_out(1'b0);
        for (int i = 0; i < 8; i++) bit_out(d[i]);
        bit_out(~(^d) ^ bad_par);
        bit_out(~bad_stop);
        pdat = 1'b1;
        repeat (30) @(negedge clk);
    endtask

    task automatic send_pkt(input logic [23:0] p);
        send_word(p[23:16], 1'b0, 1'b0);
        send_word(p[15:8], 1'b0, 1'b0);
        send_word(p[7:0], 1'b0, 1'b0);
    endtask

    task automatic idle_gap();
        repeat (IDLE + 50) @(negedge clk);
    endtask

    function automatic int sval(input logic s, input logic [7:0] m);
        return s ? int'(m) - 256 : int'(m);
    endfunction

    task automatic chk_fields(input string req, input logic [23:0] p);
        chk({req, " R2 left"},  bl, p[16]);
        chk({req, " R2 right"}, br, p[17]);
        chk({req, " R3 dx"}, $signed(dx), sval(p[20], p[15:8]));
        chk({req, " R3 dy"}, $signed(dy), sval(p[21], p[7:0]));
        chk({req, " R4 ovfx"}, ox, p[22]);
        chk({req, " R4 ovfy"}, oy, p[23]);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int v0, e0;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 dx", dx, 0); chk("R1 dy", dy, 0); chk("R1 btn", {bl, br}, 0);
        chk("R1 ovf", {ox, oy}, 0); chk("R1 strobes", {pv, fe}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 R3 R4 R10: table of packets
        for (int k = 0; k < NVEC; k++) begin
            v0 = n_valid;
            send_pkt(VEC[k]);
            chk("R2 one strobe", n_valid - v0, 1);
            chk_fields("vec", VEC[k]);
            idle_gap();
        end

        // R5: parity error in the X word; outputs hold previous packet
        v0 = n_valid; e0 = n_err;
        send_word(8'h09, 0, 0); send_word(8'h11, 1, 0); send_word(8'h22, 0, 0);
        chk("R5 err pulse", n_err - e0, 1);
        chk("R5 no packet", n_valid - v0, 0);
        chk_fields("R5 hold", VEC[NVEC-1]);
        idle_gap();

        // R6: stop-bit error in the Y word
        v0 = n_valid; e0 = n_err;
        send_word(8'h0A, 0, 0); send_word(8'h11, 0, 0); send_word(8'h22, 0, 1);
        chk("R6 err pulse", n_err - e0, 1);
        chk("R6 no packet", n_valid - v0, 0);
        idle_gap();

        // R7: unmarked status dropped, following packet still decodes
        v0 = n_valid; e0 = n_err;
        send_word(8'h00, 0, 0);
        send_pkt(24'h19_0C_F0);
        chk("R7 one packet", n_valid - v0, 1);
        chk("R7 no error", n_err - e0, 0);
        chk_fields("R7", 24'h19_0C_F0);
        idle_gap();

        // R8: idle gap mid-packet abandons partial packet
        v0 = n_valid;
        send_word(8'h39, 0, 0); send_word(8'h44, 0, 0);
        idle_gap();
        send_pkt(24'h0A_21_42);
        chk("R8 one packet", n_valid - v0, 1);
        chk_fields("R8", 24'h0A_21_42);
        idle_gap();

        // R9: after error, words ignored until a gap
        v0 = n_valid; e0 = n_err;
        send_word(8'h08, 1, 0);
        send_pkt(24'h0B_33_44);
        chk("R9 discarded", n_valid - v0, 0);
        chk("R9 single err", n_err - e0, 1);
        chk_fields("R9 hold", 24'h0A_21_42);
        idle_gap();
        send_pkt(24'h0B_33_44);
        chk("R9 recovered", n_valid - v0, 1);
        chk_fields("R9", 24'h0B_33_44);
        idle_gap();

        // R10: a high level on a falling edge does not start a word
        v0 = n_valid;
        bit_out(1'b1);
        pdat = 1'b1;
        repeat (30) @(negedge clk);
        send_pkt(24'h08_07_06);
        chk("R10 one packet", n_valid - v0, 1);
        chk_fields("R10", 24'h08_07_06);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule